// File: doc/BRIEF.md
# Reset Cause and Supply Monitor Register

This block is an 8-bit control/status register that keeps a record of why the chip last went through reset. It also carries the flag of a supply voltage detector and the two lowest bits of an oscillator trim value. Three single-cycle pulses report the reset events: external pin, watchdog and low-voltage detector. A CPU port reads and writes the register. Two PLL lock levels and a voltage-detector comparator level are shown as read-only bits. An interrupt acknowledge pulse clears the pending detector interrupt.

The two reset flags are held by a four-state machine: none, watchdog only, low-voltage only, and low-voltage plus watchdog. This machine sits in the power-on domain (`por_n`), so a CPU reset event does not wipe it. The reset events act as the CPU-domain reset for the trim field, the interrupt enable and the pending interrupt. A low-voltage event moves the machine to low-voltage only, which drops the watchdog flag. A watchdog event adds the watchdog flag and keeps any low-voltage record. A clearing read returns the machine to none. Software reads the register once after start-up to learn the cause, or it uses the decoded `cause` output.

The interrupt logic is a two-state machine, idle and pending. A rising detector level while the enable is set moves it to pending. An acknowledge moves it back to idle, and so does any reset event.

Top module: `rst_cause_reg`

## Requirements
- R1: Readback `rd_data` has this layout: bit 7 = 32 MHz PLL lock, bits 6:5 = trim, bit 4 = watchdog flag, bit 3 = PLL lock, bit 2 = low-voltage flag, bit 1 = detector flag, bit 0 = interrupt enable.
- R2: After `por_n` is released, with the PLL and detector inputs at 0, `rd_data` reads 8'h60. Both flags are 0, trim is 2'b11, the enable is 0 and `irq` is 0.
- R3: A watchdog event sets bit 4 on the next cycle. A write with bit 4 = 0 clears it. A write with bit 4 = 1 leaves it unchanged.
- R4: A low-voltage event sets bit 2 and clears bit 4 on the next cycle. It takes priority over a watchdog event in the same cycle.
- R5: A read shows the current flags in the read cycle and clears bits 4 and 2 from the next cycle. Writes never clear bit 2.
- R6: An external or watchdog event leaves bit 2 unchanged.
- R7: `cause` encodes the flags as follows: 2'd2 when bit 2 is set, 2'd1 when only bit 4 is set, 2'd0 when both are clear.
- R8: Bits 7 and 3 follow `pll32_lock` and `pll_lock` in the same cycle. Bit 1 shows `avd_level` one cycle later. Writes do not change these bits.
- R9: When `avd_level` rises while the enable is 1, `irq` goes to 1 on the next cycle. `irq_ack` returns it to 0. A rise while the enable is 0 leaves `irq` at 0.
- R10: A reset event in the same cycle as a read or write wins. The flags take the event's effect and the CPU access changes nothing.
- R11: A write loads trim from bits 6:5 and the enable from bit 0. Any reset event returns trim to 2'b11, the enable to 0 and `irq` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| evt_ext | input | 1 | External pin reset pulse |
| evt_wdg | input | 1 | Watchdog reset pulse |
| evt_lvd | input | 1 | Low-voltage reset pulse |
| cpu_rd | input | 1 | Register read strobe (clears the flags) |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| pll32_lock | input | 1 | 32 MHz PLL lock level |
| pll_lock | input | 1 | PLL lock level |
| avd_level | input | 1 | Voltage-detector comparator level |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| rd_data | output | 8 | Register readback |
| irq | output | 1 | Detector interrupt request |
| trim | output | 2 | Oscillator trim bits |
| cause | output | 2 | Decoded reset cause |

## Verification
The state with both flags set can only be reached by a set order: a low-voltage event first, then a watchdog event, with no read in between. The stimulus drives that order on purpose and then tries to clear the flags with writes, which must fail to touch the low-voltage flag. The same-cycle conflicts are also hard to reach: an event arriving together with a read, or together with an acknowledge. The directed steps place these on a single edge, and a long stretch of random sparse traffic then compares every cycle against a behavioural model.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
    localparam int REG_W    = 8;
    localparam int TRIM_W   = 2;
    localparam int CAUSE_W  = 2;

    localparam int B_PLL32  = 7;
    localparam int B_TRIM_H = 6;
    localparam int B_TRIM_L = 5;
    localparam int B_WDG    = 4;
    localparam int B_PLL    = 3;
    localparam int B_LVD    = 2;
    localparam int B_AVD    = 1;
    localparam int B_IEN    = 0;

    typedef enum logic [1:0] {
        FL_NONE    = 2'b00,
        FL_WDG     = 2'b01,
        FL_LVD     = 2'b10,
        FL_LVD_WDG = 2'b11
    } flag_state_t;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_PIN = 2'd0,
        CAUSE_WDG = 2'd1,
        CAUSE_LVD = 2'd2
    } cause_t;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_t;
endpackage

// File: rtl/rcr_flag_fsm.sv
module rcr_flag_fsm
    import rcr_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic               evt_any,
    input  logic               evt_wdg,
    input  logic               evt_lvd,
    input  logic               rd,
    input  logic               wr,
    input  logic               wr_wdg_bit,
    output logic               wdg_flag,
    output logic               lvd_flag,
    output logic [CAUSE_W-1:0] cause
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= FL_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (evt_lvd) begin
            state_d = FL_LVD;
        end else if (evt_wdg) begin
            unique case (state_q)
                FL_NONE, FL_WDG:    state_d = FL_WDG;
                FL_LVD, FL_LVD_WDG: state_d = FL_LVD_WDG;
                default:            state_d = FL_WDG;
            endcase
        end else if (evt_any) begin
            state_d = state_q;
        end else if (rd) begin
            state_d = FL_NONE;
        end else if (wr && !wr_wdg_bit) begin
            unique case (state_q)
                FL_NONE, FL_WDG:    state_d = FL_NONE;
                FL_LVD, FL_LVD_WDG: state_d = FL_LVD;
                default:            state_d = FL_NONE;
            endcase
        end
    end

    always_comb begin
        wdg_flag = 1'b0;
        lvd_flag = 1'b0;
        cause    = CAUSE_PIN;
        unique case (state_q)
            FL_NONE:    cause = CAUSE_PIN;
            FL_WDG:     begin wdg_flag = 1'b1; cause = CAUSE_WDG; end
            FL_LVD:     begin lvd_flag = 1'b1; cause = CAUSE_LVD; end
            FL_LVD_WDG: begin wdg_flag = 1'b1; lvd_flag = 1'b1; cause = CAUSE_LVD; end
            default:    cause = CAUSE_PIN;
        endcase
    end
endmodule

// File: rtl/rcr_ctrl_bits.sv
module rcr_ctrl_bits
    import rcr_pkg::*;
#(
    parameter int              T_W      = TRIM_W,
    parameter logic [T_W-1:0]  TRIM_RST = '1
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           evt_any,
    input  logic           wr,
    input  logic [T_W-1:0] wr_trim,
    input  logic           wr_ien,
    output logic [T_W-1:0] trim,
    output logic           ien
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            trim <= TRIM_RST;
            ien  <= 1'b0;
        end else if (evt_any) begin
            trim <= TRIM_RST;
            ien  <= 1'b0;
        end else if (wr) begin
            trim <= wr_trim;
            ien  <= wr_ien;
        end
    end
endmodule

// File: rtl/rcr_avd_irq.sv
module rcr_avd_irq
    import rcr_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic evt_any,
    input  logic avd_in,
    input  logic ien,
    input  logic ack,
    output logic avd_q,
    output logic irq
);
    irq_state_t st_q, st_d;
    logic       rise;

    assign rise = avd_in && !avd_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) avd_q <= 1'b0;
        else        avd_q <= avd_in;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= IRQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (evt_any) begin
            st_d = IRQ_IDLE;
        end else begin
            unique case (st_q)
                IRQ_IDLE: if (rise && ien) st_d = IRQ_PEND;
                IRQ_PEND: if (!(rise && ien) && ack) st_d = IRQ_IDLE;
                default:  st_d = IRQ_IDLE;
            endcase
        end
    end

    always_comb begin
        irq = (st_q == IRQ_PEND);
    end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rcr_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic               evt_ext,
    input  logic               evt_wdg,
    input  logic               evt_lvd,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [REG_W-1:0]   cpu_wdata,
    input  logic               pll32_lock,
    input  logic               pll_lock,
    input  logic               avd_level,
    input  logic               irq_ack,
    output logic [REG_W-1:0]   rd_data,
    output logic               irq,
    output logic [TRIM_W-1:0]  trim,
    output logic [CAUSE_W-1:0] cause
);
    logic evt_any;
    logic wdg_flag, lvd_flag, ien, avd_q;

    assign evt_any = evt_ext | evt_wdg | evt_lvd;

    rcr_flag_fsm u_flags (
        .clk        (clk),
        .por_n      (por_n),
        .evt_any    (evt_any),
        .evt_wdg    (evt_wdg),
        .evt_lvd    (evt_lvd),
        .rd         (cpu_rd),
        .wr         (cpu_wr),
        .wr_wdg_bit (cpu_wdata[B_WDG]),
        .wdg_flag   (wdg_flag),
        .lvd_flag   (lvd_flag),
        .cause      (cause)
    );

    rcr_ctrl_bits #(.T_W(TRIM_W), .TRIM_RST(2'b11)) u_ctrl (
        .clk     (clk),
        .por_n   (por_n),
        .evt_any (evt_any),
        .wr      (cpu_wr),
        .wr_trim (cpu_wdata[B_TRIM_H:B_TRIM_L]),
        .wr_ien  (cpu_wdata[B_IEN]),
        .trim    (trim),
        .ien     (ien)
    );

    rcr_avd_irq u_irq (
        .clk     (clk),
        .por_n   (por_n),
        .evt_any (evt_any),
        .avd_in  (avd_level),
        .ien     (ien),
        .ack     (irq_ack),
        .avd_q   (avd_q),
        .irq     (irq)
    );

    always_comb begin
        rd_data                    = '0;
        rd_data[B_PLL32]           = pll32_lock;
        rd_data[B_TRIM_H:B_TRIM_L] = trim;
        rd_data[B_WDG]             = wdg_flag;
        rd_data[B_PLL]             = pll_lock;
        rd_data[B_LVD]             = lvd_flag;
        rd_data[B_AVD]             = avd_q;
        rd_data[B_IEN]             = ien;
    end
endmodule

// File: rtl/rcr_checker.sv
module rcr_checker (
    input logic       clk,
    input logic       por_n,
    input logic       evt_ext,
    input logic       evt_wdg,
    input logic       evt_lvd,
    input logic       cpu_rd,
    input logic       irq_ack,
    input logic       avd_level,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic [1:0] trim,
    input logic [1:0] cause
);
    logic any_evt;
    assign any_evt = evt_ext | evt_wdg | evt_lvd;

    a_r3_wdg_sets: assert property (@(posedge clk) disable iff (!por_n)
        (evt_wdg && !evt_lvd) |=> rd_data[4]);

    a_r4_lvd_clears_wdg: assert property (@(posedge clk) disable iff (!por_n)
        evt_lvd |=> (rd_data[2] && !rd_data[4]));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_rd && !any_evt) |=> (!rd_data[4] && !rd_data[2]));

    a_r6_lvd_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (rd_data[2] && !cpu_rd) |=> rd_data[2]);

    a_r7_cause_lvd: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[2] |-> (cause == 2'd2));

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!por_n)
        (irq_ack && !(avd_level && !rd_data[1] && rd_data[0])) |=> !irq);

    a_r9_needs_enable: assert property (@(posedge clk) disable iff (!por_n)
        (!irq && !rd_data[0]) |=> !irq);

    a_r11_evt_restores: assert property (@(posedge clk) disable iff (!por_n)
        any_evt |=> (trim == 2'b11 && !rd_data[0] && !irq));
endmodule

bind rst_cause_reg rcr_checker u_rcr_checker (
    .clk       (clk),
    .por_n     (por_n),
    .evt_ext   (evt_ext),
    .evt_wdg   (evt_wdg),
    .evt_lvd   (evt_lvd),
    .cpu_rd    (cpu_rd),
    .irq_ack   (irq_ack),
    .avd_level (avd_level),
    .rd_data   (rd_data),
    .irq       (irq),
    .trim      (trim),
    .cause     (cause)
);

// File: tb/tb_rst_cause_reg.sv
module tb_rst_cause_reg;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       evt_ext = 0, evt_wdg = 0, evt_lvd = 0;
    logic       cpu_rd = 0, cpu_wr = 0;
    logic [7:0] cpu_wdata = 8'h00;
    logic       pll32_lock = 0, pll_lock = 0, avd_level = 0, irq_ack = 0;
    logic [7:0] rd_data;
    logic       irq;
    logic [1:0] trim, cause;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model state
    bit       m_wdg, m_lvd, m_ien, m_avdq, m_pend;
    bit [1:0] m_trim;

    always #2 clk = ~clk;

    rst_cause_reg dut (
        .clk(clk), .por_n(por_n), .evt_ext(evt_ext), .evt_wdg(evt_wdg),
        .evt_lvd(evt_lvd), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .pll32_lock(pll32_lock), .pll_lock(pll_lock),
        .avd_level(avd_level), .irq_ack(irq_ack), .rd_data(rd_data),
        .irq(irq), .trim(trim), .cause(cause)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_wdg = 0; m_lvd = 0; m_ien = 0; m_avdq = 0; m_pend = 0; m_trim = 2'b11;
    endtask

    function automatic logic [7:0] exp_rd();
        return {pll32_lock, m_trim, m_wdg, pll_lock, m_lvd, m_avdq, m_ien};
    endfunction

    // compare outputs to model (inputs already driven), then advance one edge
    task automatic step();
        bit any;
        #1;
        chk("R1 readback layout", rd_data, exp_rd());
        chk("R9 irq", {7'b0, irq}, {7'b0, m_pend});
        chk("R11 trim", {6'b0, trim}, {6'b0, m_trim});
        chk("R7 cause", {6'b0, cause}, m_lvd ? 8'd2 : (m_wdg ? 8'd1 : 8'd0));
        @(posedge clk);
        any = evt_ext | evt_wdg | evt_lvd;
        // R10: events win over CPU access
        if (evt_lvd) begin m_lvd = 1; m_wdg = 0; end
        else if (evt_wdg) m_wdg = 1;
        else if (!any && cpu_rd) begin m_wdg = 0; m_lvd = 0; end
        else if (!any && cpu_wr && !cpu_wdata[4]) m_wdg = 0;
        if (any) m_pend = 0;
        else if (avd_level && !m_avdq && m_ien) m_pend = 1;
        else if (irq_ack) m_pend = 0;
        m_avdq = avd_level;
        if (any) begin m_trim = 2'b11; m_ien = 0; end
        else if (cpu_wr) begin m_trim = cpu_wdata[6:5]; m_ien = cpu_wdata[0]; end
        @(negedge clk);
        evt_ext = 0; evt_wdg = 0; evt_lvd = 0;
        cpu_rd = 0; cpu_wr = 0; irq_ack = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        cpu_wr = 1; cpu_wdata = d; step();
    endtask

    initial begin
        #400000;
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        por_n = 1;
        // R2: power-on value
        #1 chk("R2 reset value", rd_data, 8'h60);
        step();
        // R3: watchdog sets, write 1 no effect, write 0 clears
        evt_wdg = 1; step(); step();
        wr(8'h70); step();
        chk("R3 write 1 keeps flag", {7'b0, rd_data[4]}, 8'd1);
        wr(8'h60); step();
        // R4: watchdog then low-voltage; low-voltage clears watchdog
        evt_wdg = 1; step();
        evt_lvd = 1; evt_wdg = 1; step();
        chk("R4 lvd wins", {5'b0, rd_data[4:2]}, 8'b001);
        // R6: external and watchdog keep the low-voltage flag
        evt_ext = 1; step();
        evt_wdg = 1; step();
        chk("R6 both flags", {5'b0, rd_data[4:2]}, 8'b101);
        // R5: writes never clear the low-voltage flag
        wr(8'h60); step();
        chk("R5 write leaves lvd", {7'b0, rd_data[2]}, 8'd1);
        cpu_rd = 1; step(); step();
        chk("R5 read clears", {5'b0, rd_data[4:2]}, 8'b000);
        // R10: event beside a read
        cpu_rd = 1; evt_wdg = 1; step(); step();
        cpu_rd = 1; evt_ext = 1; step();
        // R8 / R11: writes to read-only bits ignored, trim and enable writable
        wr(8'hBF); pll32_lock = 1; step(); pll_lock = 1; step();
        pll32_lock = 0; step();
        // R9: detector rise with enable
        avd_level = 1; step(); step();
        irq_ack = 1; step(); step();
        avd_level = 0; step();
        wr(8'h20); avd_level = 1; step(); step();
        chk("R9 no irq when disabled", {7'b0, irq}, 8'd0);
        // R11: reset event restores trim/enable and drops pending irq
        avd_level = 0; wr(8'h01); avd_level = 1; step();
        evt_ext = 1; step(); step();
        // random sparse traffic
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            evt_ext = (r == 0); evt_wdg = (r == 1) || (r == 2); evt_lvd = (r == 3);
            cpu_rd = ($urandom_range(0, 9) == 0);
            cpu_wr = ($urandom_range(0, 7) == 0);
            cpu_wdata = 8'($urandom);
            irq_ack = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 6) == 0) avd_level = ~avd_level;
            if ($urandom_range(0, 20) == 0) pll_lock = ~pll_lock;
            if ($urandom_range(0, 20) == 0) pll32_lock = ~pll32_lock;
            step();
        end
        // power-on reset mid-run returns everything
        por_n = 0; avd_level = 0; pll_lock = 0; pll32_lock = 0;
        @(negedge clk); por_n = 1; model_reset();
        #1 chk("R2 second power-on", rd_data, 8'h60);
        step();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule